// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged Data Cache with Synonym Purge

This block is a direct-mapped first-level data cache whose set is chosen from virtual address bits, so the array can be read in the same cycle that the translation unit looks up the page. The physical page number (PPN) from translation arrives in that same cycle and is compared against the PPN stored with the line. Hit detection therefore needs both the virtual index and the translated page. Translation and main memory sit outside the block. The processor side issues one request at a time and waits for its response.

With 4 KiB pages, 64-byte lines and 128 sets, the set index covers VA[12:6]. Bit 12 lies above the page offset, so two virtual pages that map the same physical page can place one physical line in two different sets. A physically indexed directory tracks every line in the cache. It is indexed by PA[12:6], and each entry holds PA[31:13] plus the virtual alias bit under which the line was filled.

On a miss the directory is consulted first. It may hold the same physical line under the other alias bit, or a different physical line in the same directory slot. In either case that copy is purged from the cache, and written back if dirty. The current occupant of the target set is evicted next. The line is then fetched, and the directory entry is rewritten with the new alias bit. At most one copy of any physical line is ever cached. Each line is modelled as a single DATA_W-bit payload.

Top module: `vipt_alias_cache`

## Requirements
- R1: After reset, `stall`, `resp_valid`, `mem_rd_req` and `wb_valid` are low, and every line is invalid, so the first access to any address misses.
- R2: A read or write is accepted when `req_valid` is high and `stall` is low. If the set VA[12:6] holds a valid line whose stored PPN equals `tlb_ppn`, then `resp_valid` and `resp_hit` are high exactly one cycle later, `resp_rdata` carries the line data, and `stall` stays low.
- R3: A valid line in the indexed set whose stored PPN differs from `tlb_ppn` is a miss. The set index alone never produces a hit.
- R4: After a miss is accepted, `stall` is high from the next cycle through the response cycle. The fill is requested on `mem_rd_req` at the line address {PPN, VA[11:6], 6'b0}. The response comes 3 + MEM_LAT cycles after acceptance, or one cycle later when a purge is needed. MEM_LAT is the number of cycles `mem_rd_req` is high up to and including the cycle with `mem_rd_valid`.
- R5: A read miss responds with `resp_hit` low and the memory data. A repeat of the same access then hits.
- R6: Writes replace the line payload. A write hit marks the line dirty. A write miss allocates the line, merges the write data, and leaves the line dirty.
- R7: When the directory holds the requested physical line under the other alias bit, the copy in the other set is purged before the fill. Accessing the old virtual address afterwards misses.
- R8: A purged dirty copy is written back on `wb_valid` with its physical line address and data, before the fill is requested. A clean copy produces no write-back.
- R9: When a different line occupies the target set, it is evicted. It is written back only if dirty, and it misses on its next access.
- R10: When the directory slot PA[12:6] holds a different physical line, that line is purged from the cache before the fill (written back if dirty), which keeps the directory inclusive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_vaddr | input | 32 | Virtual byte address; set index is VA[12:6] |
| req_wdata | input | DATA_W | Write payload |
| tlb_ppn | input | 20 | Physical page number for `req_vaddr`, valid with the request |
| stall | output | 1 | High while a miss is being serviced |
| resp_valid | output | 1 | Response pulse |
| resp_hit | output | 1 | Response came from a hit |
| resp_rdata | output | DATA_W | Line payload after the access |
| mem_rd_req | output | 1 | Fill request, held until data returns |
| mem_rd_addr | output | 32 | Physical line address of the fill |
| mem_rd_valid | input | 1 | Fill data present |
| mem_rd_data | input | DATA_W | Fill payload |
| wb_valid | output | 1 | Write-back pulse |
| wb_addr | output | 32 | Physical line address written back |
| wb_data | output | DATA_W | Written-back payload |

## Verification
A hit answers exactly one cycle after acceptance. A miss answers 3 + MEM_LAT cycles after acceptance, or 4 + MEM_LAT cycles when the directory forces a purge. Each access task samples on falling edges and counts cycles from acceptance to the `resp_valid` pulse. It compares that count with the figure expected for the hit, plain-miss or purge case, so an extra or missing purge shows up as a latency error. The task also checks that `stall` holds high on every sampled cycle of a miss. A memory model records write-back pulses and fill addresses as they occur, and the task compares them after the response.

// File: rtl/vipt_cfg_pkg.sv
package vipt_cfg_pkg;
  localparam int VA_W    = 32;
  localparam int PA_W    = 32;
  localparam int PAGE_W  = 12;
  localparam int LINE_W  = 6;
  localparam int SET_W   = 7;
  localparam int ALIAS_W = SET_W + LINE_W - PAGE_W;
  localparam int LOW_W   = SET_W - ALIAS_W;
  localparam int PPN_W   = PA_W - PAGE_W;
  localparam int NSETS   = 1 << SET_W;
  localparam int DTAG_W  = PA_W - LINE_W - SET_W;

  typedef logic [SET_W-1:0]   set_t;
  typedef logic [PPN_W-1:0]   ppn_t;
  typedef logic [DTAG_W-1:0]  dtag_t;
  typedef logic [ALIAS_W-1:0] alias_t;
  typedef logic [PA_W-1:0]    pa_t;
  typedef logic [VA_W-1:0]    va_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DIR, ST_PURGE, ST_EVICT, ST_FILL, ST_RESP
  } mst_t;

  // set chosen from untranslated virtual bits
  function automatic set_t va_set(va_t va);
    return va[LINE_W +: SET_W];
  endfunction

  // physical line address of a line held in cache set s under page ppn
  function automatic pa_t line_pa(ppn_t ppn, set_t s);
    return {ppn, s[LOW_W-1:0], {LINE_W{1'b0}}};
  endfunction

  function automatic set_t dir_index(pa_t pa);
    return pa[LINE_W +: SET_W];
  endfunction

  function automatic dtag_t dir_tag(pa_t pa);
    return pa[PA_W-1 -: DTAG_W];
  endfunction

  function automatic alias_t set_alias(set_t s);
    return s[SET_W-1 -: ALIAS_W];
  endfunction

  function automatic set_t with_alias(alias_t a, set_t s);
    return {a, s[LOW_W-1:0]};
  endfunction
endpackage

// File: rtl/vipt_l1_array.sv
module vipt_l1_array
  import vipt_cfg_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  set_t              rd_set,
  output logic              rd_valid,
  output ppn_t              rd_ppn,
  output logic              rd_dirty,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  set_t              wr_set,
  input  logic              wr_valid,
  input  ppn_t              wr_ppn,
  input  logic              wr_dirty,
  input  logic [DATA_W-1:0] wr_data
);
  logic [NSETS-1:0]  vld_q;
  logic [NSETS-1:0]  dirty_q;
  ppn_t              ppn_m  [NSETS];
  logic [DATA_W-1:0] data_m [NSETS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q   <= '0;
      dirty_q <= '0;
    end else if (wr_en) begin
      vld_q[wr_set]   <= wr_valid;
      dirty_q[wr_set] <= wr_valid & wr_dirty;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && wr_valid) begin
      ppn_m[wr_set]  <= wr_ppn;
      data_m[wr_set] <= wr_data;
    end
  end

  assign rd_valid = vld_q[rd_set];
  assign rd_dirty = dirty_q[rd_set];
  assign rd_ppn   = ppn_m[rd_set];
  assign rd_data  = data_m[rd_set];
endmodule

// File: rtl/vipt_alias_dir.sv
module vipt_alias_dir
  import vipt_cfg_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  set_t   rd_idx,
  output logic   rd_valid,
  output dtag_t  rd_tag,
  output alias_t rd_alias,
  input  logic   wr_en,
  input  set_t   wr_idx,
  input  logic   wr_valid,
  input  dtag_t  wr_tag,
  input  alias_t wr_alias
);
  logic [NSETS-1:0] vld_q;
  dtag_t            tag_m   [NSETS];
  alias_t           alias_m [NSETS];

  always_ff @(posedge clk) begin
    if (!rst_n)     vld_q <= '0;
    else if (wr_en) vld_q[wr_idx] <= wr_valid;
  end

  always_ff @(posedge clk) begin
    if (wr_en && wr_valid) begin
      tag_m[wr_idx]   <= wr_tag;
      alias_m[wr_idx] <= wr_alias;
    end
  end

  assign rd_valid = vld_q[rd_idx];
  assign rd_tag   = tag_m[rd_idx];
  assign rd_alias = alias_m[rd_idx];
endmodule

// File: rtl/vipt_miss_ctrl.sv
module vipt_miss_ctrl
  import vipt_cfg_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  va_t               req_vaddr,
  input  logic [DATA_W-1:0] req_wdata,
  input  ppn_t              tlb_ppn,
  output set_t              l1_rd_set,
  input  logic              l1_rd_valid,
  input  ppn_t              l1_rd_ppn,
  input  logic              l1_rd_dirty,
  input  logic [DATA_W-1:0] l1_rd_data,
  output logic              l1_wr_en,
  output set_t              l1_wr_set,
  output logic              l1_wr_valid,
  output ppn_t              l1_wr_ppn,
  output logic              l1_wr_dirty,
  output logic [DATA_W-1:0] l1_wr_data,
  output set_t              dir_rd_idx,
  input  logic              dir_rd_valid,
  input  dtag_t             dir_rd_tag,
  input  alias_t            dir_rd_alias,
  output logic              dir_wr_en,
  output set_t              dir_wr_idx,
  output logic              dir_wr_valid,
  output dtag_t             dir_wr_tag,
  output alias_t            dir_wr_alias,
  output logic              stall,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic [DATA_W-1:0] resp_rdata,
  output logic              mem_rd_req,
  output pa_t               mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              wb_valid,
  output pa_t               wb_addr,
  output logic [DATA_W-1:0] wb_data
);
  mst_t              state_q;
  set_t              set_q, tgt_q;
  ppn_t              ppn_q;
  logic              write_q;
  logic [DATA_W-1:0] wdata_q;

  set_t              req_set;
  pa_t               fill_pa;
  logic              accept, hit_evt, miss_evt, syn_evt, conf_evt;
  logic              purge_evt, evict_evt, fill_done;
  logic [DATA_W-1:0] fill_data;
  logic              unused_va;

  assign unused_va = ^{req_vaddr[VA_W-1:LINE_W+SET_W], req_vaddr[LINE_W-1:0]};
  assign req_set   = va_set(req_vaddr);
  assign fill_pa   = line_pa(ppn_q, set_q);
  assign l1_rd_set = (state_q == ST_IDLE)  ? req_set :
                     (state_q == ST_PURGE) ? tgt_q : set_q;
  assign dir_rd_idx = dir_index(fill_pa);

  // named events
  assign accept    = (state_q == ST_IDLE) && req_valid;
  assign hit_evt   = accept && l1_rd_valid && (l1_rd_ppn == tlb_ppn);
  assign miss_evt  = accept && !hit_evt;
  assign syn_evt   = (state_q == ST_DIR) && dir_rd_valid &&
                     (dir_rd_tag == dir_tag(fill_pa)) && (dir_rd_alias != set_alias(set_q));
  assign conf_evt  = (state_q == ST_DIR) && dir_rd_valid && (dir_rd_tag != dir_tag(fill_pa));
  assign purge_evt = (state_q == ST_PURGE) && l1_rd_valid;
  assign evict_evt = (state_q == ST_EVICT) && l1_rd_valid;
  assign fill_done = (state_q == ST_FILL) && mem_rd_valid;
  assign fill_data = write_q ? wdata_q : mem_rd_data;

  assign stall       = (state_q != ST_IDLE);
  assign mem_rd_req  = (state_q == ST_FILL);
  assign mem_rd_addr = fill_pa;
  assign wb_valid    = (purge_evt || evict_evt) && l1_rd_dirty;
  assign wb_addr     = line_pa(l1_rd_ppn, l1_rd_set);
  assign wb_data     = l1_rd_data;

  always_comb begin
    l1_wr_en    = 1'b0;
    l1_wr_set   = set_q;
    l1_wr_valid = 1'b0;
    l1_wr_ppn   = ppn_q;
    l1_wr_dirty = 1'b0;
    l1_wr_data  = fill_data;
    if (hit_evt && req_write) begin
      l1_wr_en    = 1'b1;
      l1_wr_set   = req_set;
      l1_wr_valid = 1'b1;
      l1_wr_ppn   = tlb_ppn;
      l1_wr_dirty = 1'b1;
      l1_wr_data  = req_wdata;
    end else if (purge_evt || evict_evt) begin
      l1_wr_en  = 1'b1;
      l1_wr_set = l1_rd_set;
    end else if (fill_done) begin
      l1_wr_en    = 1'b1;
      l1_wr_valid = 1'b1;
      l1_wr_dirty = write_q;
    end
  end

  always_comb begin
    dir_wr_en    = purge_evt || evict_evt || fill_done;
    dir_wr_idx   = evict_evt ? dir_index(wb_addr) : dir_rd_idx;
    dir_wr_valid = fill_done;
    dir_wr_tag   = dir_tag(fill_pa);
    dir_wr_alias = set_alias(set_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      set_q      <= '0;
      tgt_q      <= '0;
      ppn_q      <= '0;
      write_q    <= 1'b0;
      wdata_q    <= '0;
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_rdata <= '0;
    end else begin
      resp_valid <= hit_evt || fill_done;
      resp_hit   <= hit_evt;
      if (hit_evt)   resp_rdata <= req_write ? req_wdata : l1_rd_data;
      if (fill_done) resp_rdata <= fill_data;
      unique case (state_q)
        ST_IDLE: if (miss_evt) begin
          set_q   <= req_set;
          ppn_q   <= tlb_ppn;
          write_q <= req_write;
          wdata_q <= req_wdata;
          state_q <= ST_DIR;
        end
        ST_DIR: begin
          tgt_q   <= with_alias(dir_rd_alias, set_q);
          state_q <= (syn_evt || conf_evt) ? ST_PURGE : ST_EVICT;
        end
        ST_PURGE: state_q <= ST_EVICT;
        ST_EVICT: state_q <= ST_FILL;
        ST_FILL:  if (mem_rd_valid) state_q <= ST_RESP;
        ST_RESP:  state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  a_r2_hit_answers_next: assert property (@(posedge clk) disable iff (!rst_n)
    hit_evt |=> (resp_valid && resp_hit));
  a_r4_stall_until_resp: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !resp_valid) |=> stall);
  a_r5_fill_answers_miss: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> (resp_valid && !resp_hit));
  a_r6_write_hit_data: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_evt && req_write) |=> (resp_rdata == $past(req_wdata)));
  a_r7_synonym_purges_other: assert property (@(posedge clk) disable iff (!rst_n)
    syn_evt |=> ((state_q == ST_PURGE) && (tgt_q != set_q)));
  a_r10_conflict_purges: assert property (@(posedge clk) disable iff (!rst_n)
    conf_evt |=> (state_q == ST_PURGE));
  a_r8_no_wb_while_filling: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> !wb_valid);
endmodule

// File: rtl/vipt_alias_cache.sv
module vipt_alias_cache
  import vipt_cfg_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [PPN_W-1:0]  tlb_ppn,
  output logic              stall,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic [DATA_W-1:0] resp_rdata,
  output logic              mem_rd_req,
  output logic [PA_W-1:0]   mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              wb_valid,
  output logic [PA_W-1:0]   wb_addr,
  output logic [DATA_W-1:0] wb_data
);
  set_t              l1_rd_set, l1_wr_set, dir_rd_idx, dir_wr_idx;
  logic              l1_rd_valid, l1_rd_dirty, l1_wr_en, l1_wr_valid, l1_wr_dirty;
  ppn_t              l1_rd_ppn, l1_wr_ppn;
  logic [DATA_W-1:0] l1_rd_data, l1_wr_data;
  logic              dir_rd_valid, dir_wr_en, dir_wr_valid;
  dtag_t             dir_rd_tag, dir_wr_tag;
  alias_t            dir_rd_alias, dir_wr_alias;

  vipt_l1_array #(.DATA_W(DATA_W)) u_l1 (
    .clk, .rst_n,
    .rd_set(l1_rd_set), .rd_valid(l1_rd_valid), .rd_ppn(l1_rd_ppn),
    .rd_dirty(l1_rd_dirty), .rd_data(l1_rd_data),
    .wr_en(l1_wr_en), .wr_set(l1_wr_set), .wr_valid(l1_wr_valid),
    .wr_ppn(l1_wr_ppn), .wr_dirty(l1_wr_dirty), .wr_data(l1_wr_data)
  );

  vipt_alias_dir u_dir (
    .clk, .rst_n,
    .rd_idx(dir_rd_idx), .rd_valid(dir_rd_valid), .rd_tag(dir_rd_tag), .rd_alias(dir_rd_alias),
    .wr_en(dir_wr_en), .wr_idx(dir_wr_idx), .wr_valid(dir_wr_valid),
    .wr_tag(dir_wr_tag), .wr_alias(dir_wr_alias)
  );

  vipt_miss_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk, .rst_n,
    .req_valid, .req_write, .req_vaddr, .req_wdata, .tlb_ppn,
    .l1_rd_set, .l1_rd_valid, .l1_rd_ppn, .l1_rd_dirty, .l1_rd_data,
    .l1_wr_en, .l1_wr_set, .l1_wr_valid, .l1_wr_ppn, .l1_wr_dirty, .l1_wr_data,
    .dir_rd_idx, .dir_rd_valid, .dir_rd_tag, .dir_rd_alias,
    .dir_wr_en, .dir_wr_idx, .dir_wr_valid, .dir_wr_tag, .dir_wr_alias,
    .stall, .resp_valid, .resp_hit, .resp_rdata,
    .mem_rd_req, .mem_rd_addr, .mem_rd_valid, .mem_rd_data,
    .wb_valid, .wb_addr, .wb_data
  );
endmodule

// File: tb/vipt_alias_cache_tb_top.sv
module vipt_alias_cache_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_LAT    = 3;
  localparam int DW         = 32;
  localparam int MISS_LAT   = 3 + MEM_LAT;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [31:0]   req_vaddr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [19:0]   tlb_ppn = '0;
  logic          stall, resp_valid, resp_hit, mem_rd_req, wb_valid;
  logic [DW-1:0] resp_rdata, wb_data;
  logic [31:0]   mem_rd_addr, wb_addr;
  logic          mem_rd_valid = 1'b0;
  logic [DW-1:0] mem_rd_data = '0;

  int n_cmp = 0, n_bad = 0;
  logic [DW-1:0] mem_q [int];
  int          wb_n = 0;
  logic [31:0] wb_a_log [4];
  logic [DW-1:0] wb_d_log [4];
  logic [31:0] last_fill_addr = '0;

  vipt_alias_cache #(.DATA_W(DW)) dut_i (
    .clk, .rst_n, .req_valid, .req_write, .req_vaddr, .req_wdata, .tlb_ppn,
    .stall, .resp_valid, .resp_hit, .resp_rdata,
    .mem_rd_req, .mem_rd_addr, .mem_rd_valid, .mem_rd_data,
    .wb_valid, .wb_addr, .wb_data
  );

  initial forever #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [DW-1:0] mem_peek(logic [31:0] pa);
    int line = int'(pa >> 6);
    if (mem_q.exists(line)) return mem_q[line];
    return pa * 32'h0001_0003 + 32'h1357_0000;
  endfunction

  // memory model: fill after MEM_LAT cycles of request, log write-backs
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (wb_valid) begin
        mem_q[int'(wb_addr >> 6)] = wb_data;
        if (wb_n < 4) begin
          wb_a_log[wb_n] = wb_addr;
          wb_d_log[wb_n] = wb_data;
        end
        wb_n++;
      end
      if (mem_rd_req && !mem_rd_valid) begin
        cnt++;
        if (cnt == MEM_LAT) begin
          mem_rd_valid   = 1'b1;
          mem_rd_data    = mem_peek(mem_rd_addr);
          last_fill_addr = mem_rd_addr;
        end
      end else begin
        mem_rd_valid = 1'b0;
        cnt = 0;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [31:0] va, input logic [19:0] ppn,
                        input logic [DW-1:0] wd, output int lat, output bit hit,
                        output logic [DW-1:0] data, output bit stall_ok);
    @(negedge clk);
    wb_n = 0;
    req_valid = 1'b1; req_write = wr; req_vaddr = va; tlb_ppn = ppn; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    stall_ok = 1'b1;
    while (!resp_valid && lat < 60) begin
      if (!stall) stall_ok = 1'b0;
      @(negedge clk);
      lat++;
    end
    hit  = resp_hit;
    data = resp_rdata;
    if (hit == stall) stall_ok = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 stall", 32'(stall), 0);
    chk("R1 resp_valid", 32'(resp_valid), 0);
    chk("R1 mem_rd_req", 32'(mem_rd_req), 0);
    chk("R1 wb_valid", 32'(wb_valid), 0);
  endtask

  task automatic t_cold_miss_then_hit;
    int lat; bit hit, sok; logic [DW-1:0] d; logic [DW-1:0] exp;
    exp = mem_peek(32'h0002_2040);
    access(0, 32'h0000_1040, 20'h00022, '0, lat, hit, d, sok);
    chk("R1 cold access misses", 32'(hit), 0);
    chk("R4 miss latency", lat, MISS_LAT);
    chk("R4 stall through miss", 32'(sok), 1);
    chk("R4 fill line address", last_fill_addr, 32'h0002_2040);
    chk("R5 read miss data", d, exp);
    chk("R8 clean miss no write-back", wb_n, 0);
    access(0, 32'h0000_1040, 20'h00022, '0, lat, hit, d, sok);
    chk("R2 repeat read hits", 32'(hit), 1);
    chk("R2 hit latency", lat, 1);
    chk("R2 stall low on hit", 32'(sok), 1);
    chk("R5 hit data", d, exp);
  endtask

  task automatic t_ppn_mismatch;
    int lat; bit hit, sok; logic [DW-1:0] d;
    access(0, 32'h0000_1040, 20'h00025, '0, lat, hit, d, sok);
    chk("R3 same set other page misses", 32'(hit), 0);
    chk("R3 no purge latency", lat, MISS_LAT);
    chk("R9 clean victim not written back", wb_n, 0);
    access(0, 32'h0000_1040, 20'h00022, '0, lat, hit, d, sok);
    chk("R9 evicted line misses", 32'(hit), 0);
    access(0, 32'h0000_1040, 20'h00025, '0, lat, hit, d, sok);
    chk("R9 reloaded line misses", 32'(hit), 0);
  endtask

  task automatic t_write_hit;
    int lat; bit hit, sok; logic [DW-1:0] d;
    access(1, 32'h0000_1040, 20'h00025, 32'hDEAD_0001, lat, hit, d, sok);
    chk("R6 write hit", 32'(hit), 1);
    chk("R6 write hit latency", lat, 1);
    access(0, 32'h0000_1040, 20'h00025, '0, lat, hit, d, sok);
    chk("R6 read after write", d, 32'hDEAD_0001);
  endtask

  task automatic t_synonym;
    int lat; bit hit, sok; logic [DW-1:0] d;
    access(0, 32'h0000_0040, 20'h00025, '0, lat, hit, d, sok);
    chk("R7 synonym misses", 32'(hit), 0);
    chk("R7 purge adds one cycle", lat, MISS_LAT + 1);
    chk("R8 dirty purge writes back once", wb_n, 1);
    chk("R8 write-back address", wb_a_log[0], 32'h0002_5040);
    chk("R8 write-back data", wb_d_log[0], 32'hDEAD_0001);
    chk("R7 synonym sees written data", d, 32'hDEAD_0001);
    access(0, 32'h0000_1040, 20'h00025, '0, lat, hit, d, sok);
    chk("R7 old alias no longer cached", 32'(hit), 0);
    chk("R7 old alias purge latency", lat, MISS_LAT + 1);
    chk("R8 clean purge no write-back", wb_n, 0);
    chk("R7 old alias data", d, 32'hDEAD_0001);
  endtask

  task automatic t_dirty_victim;
    int lat; bit hit, sok; logic [DW-1:0] d; logic [DW-1:0] exp;
    access(1, 32'h0000_1040, 20'h00025, 32'hBEEF_0002, lat, hit, d, sok);
    chk("R6 write hit second", 32'(hit), 1);
    exp = mem_peek(32'h0003_6040);
    access(0, 32'h0000_3040, 20'h00036, '0, lat, hit, d, sok);
    chk("R9 victim case latency", lat, MISS_LAT);
    chk("R9 dirty victim written back", wb_n, 1);
    chk("R9 victim address", wb_a_log[0], 32'h0002_5040);
    chk("R9 victim data", wb_d_log[0], 32'hBEEF_0002);
    chk("R5 new line data", d, exp);
  endtask

  task automatic t_dir_conflict;
    int lat; bit hit, sok; logic [DW-1:0] d;
    access(1, 32'h0000_3040, 20'h00036, 32'hCAFE_0003, lat, hit, d, sok);
    chk("R6 write hit third", 32'(hit), 1);
    access(0, 32'h0000_0040, 20'h00038, '0, lat, hit, d, sok);
    chk("R10 conflict purge latency", lat, MISS_LAT + 1);
    chk("R10 conflicting dirty line written back", wb_n, 1);
    chk("R10 write-back address", wb_a_log[0], 32'h0003_6040);
    chk("R10 write-back data", wb_d_log[0], 32'hCAFE_0003);
    access(0, 32'h0000_3040, 20'h00036, '0, lat, hit, d, sok);
    chk("R10 purged line misses", 32'(hit), 0);
    chk("R10 purged line data", d, 32'hCAFE_0003);
  endtask

  task automatic t_write_miss;
    int lat; bit hit, sok; logic [DW-1:0] d;
    access(1, 32'h0000_5080, 20'h00041, 32'h7777_0004, lat, hit, d, sok);
    chk("R6 write miss allocates", 32'(hit), 0);
    chk("R6 write miss data", d, 32'h7777_0004);
    access(0, 32'h0000_5080, 20'h00041, '0, lat, hit, d, sok);
    chk("R6 write-allocated line hits", 32'(hit), 1);
    access(0, 32'h0000_7080, 20'h00042, '0, lat, hit, d, sok);
    chk("R6 allocated line dirty on eviction", wb_n, 1);
    chk("R6 eviction data", wb_d_log[0], 32'h7777_0004);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cold_miss_then_hit();
    t_ppn_mismatch();
    t_write_hit();
    t_synonym();
    t_dirty_victim();
    t_dir_conflict();
    t_write_miss();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule